// File: doc/BRIEF.md
# Dual-Issue Dispatch and Steering Logic

This block sits between an in-order instruction queue and the execution units of a small two-wide core. Each cycle it looks at the two oldest queue entries, each carrying a 4-bit class code. It decides how many of them issue and sends each granted entry to a target unit. The targets are two simple integer pipes, a multiply/divide unit, a load/store unit and a branch unit. The grants, the unit selects and the consume count are combinational from the current class codes, the multiply-busy input and one small piece of internal state.

The two simple pipes are not equal. Pipe B can run every simple operation. Pipe A cannot run the restricted subset: condition-register moves, simple vector ops, vector compares and vector permutes. Those go to pipe B only. A restricted operation placed behind an unrestricted simple operation cannot issue with it in the same cycle. The reverse order pairs normally.

Multi-part classes keep pipe A and one issue slot busy for one or two cycles after they issue. A countdown register tracks this. Issue is strictly in order: the younger entry never issues when the older one does not.

Top module: `dual_issue_steer`

## Requirements
- R1: Class codes are: 0 bubble, 1 simple-any, 2 simple-restricted, 3 two-part, 4 three-part, 5 branch, 6 multiply, 7 divide, 8 load, 9 store. Codes 10 to 15 count as bubbles. Unit codes are: 0 none, 1 pipe A, 2 pipe B, 3 multiply/divide, 4 load/store, 5 branch. After reset, or when the older entry is a bubble, no grant is given, both unit selects are 0 and the consume count is 0.
- R2: The younger entry is granted only when the older entry is granted in the same cycle. The consume count equals the number of grants (0, 1 or 2).
- R3: A simple-any entry goes to pipe A when pipe A is free. Otherwise it goes to pipe B. It is not granted when neither pipe is free.
- R4: A simple-restricted entry goes only to pipe B. Two restricted entries never issue in the same cycle.
- R5: When the older entry is simple-any and the younger is simple-restricted, only the older entry issues. A restricted older entry followed by a simple-any younger entry issues both: older to pipe B, younger to pipe A.
- R6: Branch entries go to unit 5, and load and store entries go to unit 4. At most one entry enters each of these units per cycle.
- R7: Multiply and divide entries go to unit 3, at most one per cycle. Neither is granted while mul_busy_i is high.
- R8: A two-part or three-part entry needs pipe A and issues to unit 1. For the next 1 (two-part) or 2 (three-part) cycles, the following hold: only the older queue entry may be granted, pipe A is not selected, and no other multi-part entry issues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cls0_i | input | 4 | Class code of the older queue entry |
| cls1_i | input | 4 | Class code of the younger queue entry |
| mul_busy_i | input | 1 | Multiply/divide unit cannot accept a new operation |
| grant0_o | output | 1 | Older entry issues this cycle |
| grant1_o | output | 1 | Younger entry issues this cycle |
| unit0_o | output | 3 | Target unit code for the older entry |
| unit1_o | output | 3 | Target unit code for the younger entry |
| consume_o | output | 2 | Number of entries taken from the queue |

## Verification
The assertions assume the queue moves forward by exactly consume_o entries. They also assume the class codes and mul_busy_i settle well before each rising edge, so the sampled grants match the state held in the hold countdown. They accept any 4-bit code, including the unassigned ones. The stimulus changes every input on the falling edge and samples outputs shortly before the next rising edge. Each multi-part sequence is followed for its whole hold window before new entries are expected to pair again, so the bench's expected values always start from a known countdown value.

// File: rtl/dd_pkg.sv
package dd_pkg;
  localparam int CLS_W  = 4;
  localparam int UNIT_W = 3;
  localparam int HOLD_W = 2;

  localparam logic [CLS_W-1:0] C_SANY  = 4'd1;
  localparam logic [CLS_W-1:0] C_SRES  = 4'd2;
  localparam logic [CLS_W-1:0] C_TWO   = 4'd3;
  localparam logic [CLS_W-1:0] C_THREE = 4'd4;
  localparam logic [CLS_W-1:0] C_BR    = 4'd5;
  localparam logic [CLS_W-1:0] C_MUL   = 4'd6;
  localparam logic [CLS_W-1:0] C_DIV   = 4'd7;
  localparam logic [CLS_W-1:0] C_LD    = 4'd8;
  localparam logic [CLS_W-1:0] C_ST    = 4'd9;

  localparam logic [UNIT_W-1:0] U_NONE = 3'd0;
  localparam logic [UNIT_W-1:0] U_PA   = 3'd1;
  localparam logic [UNIT_W-1:0] U_PB   = 3'd2;
  localparam logic [UNIT_W-1:0] U_MD   = 3'd3;
  localparam logic [UNIT_W-1:0] U_LS   = 3'd4;
  localparam logic [UNIT_W-1:0] U_BR   = 3'd5;

  typedef struct packed {
    logic              vld;
    logic              sany;
    logic              sres;
    logic              multi;
    logic [HOLD_W-1:0] extra;
    logic              br;
    logic              md;
    logic              ls;
  } need_t;
endpackage

// File: rtl/dd_classify.sv
module dd_classify
  import dd_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  output need_t            need_o
);
  always_comb begin
    need_o = '0;
    unique case (cls_i)
      C_SANY:  begin need_o.vld = 1'b1; need_o.sany = 1'b1; end
      C_SRES:  begin need_o.vld = 1'b1; need_o.sres = 1'b1; end
      C_TWO:   begin need_o.vld = 1'b1; need_o.multi = 1'b1; need_o.extra = 2'd1; end
      C_THREE: begin need_o.vld = 1'b1; need_o.multi = 1'b1; need_o.extra = 2'd2; end
      C_BR:    begin need_o.vld = 1'b1; need_o.br = 1'b1; end
      C_MUL, C_DIV: begin need_o.vld = 1'b1; need_o.md = 1'b1; end
      C_LD, C_ST:   begin need_o.vld = 1'b1; need_o.ls = 1'b1; end
      default: need_o = '0;
    endcase
  end
endmodule

// File: rtl/dd_hold.sv
module dd_hold
  import dd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [HOLD_W-1:0] extra_i,
  output logic              busy_o
);
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              hold_en;

  always_comb begin
    hold_en = busy_o || start_i;
    if (busy_o) hold_d = hold_q - 1'b1;
    else        hold_d = extra_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign busy_o = (hold_q != '0);

  a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (hold_q == $past(hold_q) - 1'b1));
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !start_i);
endmodule

// File: rtl/dd_arbiter.sv
module dd_arbiter
  import dd_pkg::*;
(
  input  need_t              need0_i,
  input  need_t              need1_i,
  input  logic               hold_i,
  input  logic               mul_busy_i,
  output logic [1:0]         grant_o,
  output logic [UNIT_W-1:0]  unit0_o,
  output logic [UNIT_W-1:0]  unit1_o,
  output logic               start_o,
  output logic [HOLD_W-1:0]  extra_o
);
  logic pa_used, pb_used;

  always_comb begin
    grant_o = 2'b00;
    unit0_o = U_NONE;
    unit1_o = U_NONE;
    if (need0_i.vld) begin
      if (need0_i.sany) begin
        grant_o[0] = 1'b1;
        unit0_o    = hold_i ? U_PB : U_PA;
      end else if (need0_i.sres) begin
        grant_o[0] = 1'b1;
        unit0_o    = U_PB;
      end else if (need0_i.multi) begin
        grant_o[0] = !hold_i;
        unit0_o    = hold_i ? U_NONE : U_PA;
      end else if (need0_i.br) begin
        grant_o[0] = 1'b1;
        unit0_o    = U_BR;
      end else if (need0_i.ls) begin
        grant_o[0] = 1'b1;
        unit0_o    = U_LS;
      end else if (need0_i.md) begin
        grant_o[0] = !mul_busy_i;
        unit0_o    = mul_busy_i ? U_NONE : U_MD;
      end
    end
    pa_used = (unit0_o == U_PA);
    pb_used = (unit0_o == U_PB);
    if (grant_o[0] && !hold_i && need1_i.vld) begin
      if (need1_i.sany) begin
        if (!pa_used) begin
          grant_o[1] = 1'b1; unit1_o = U_PA;
        end else if (!pb_used) begin
          grant_o[1] = 1'b1; unit1_o = U_PB;
        end
      end else if (need1_i.sres) begin
        if (!pb_used && !need0_i.sany) begin
          grant_o[1] = 1'b1; unit1_o = U_PB;
        end
      end else if (need1_i.multi) begin
        if (!pa_used) begin
          grant_o[1] = 1'b1; unit1_o = U_PA;
        end
      end else if (need1_i.br) begin
        if (unit0_o != U_BR) begin
          grant_o[1] = 1'b1; unit1_o = U_BR;
        end
      end else if (need1_i.ls) begin
        if (unit0_o != U_LS) begin
          grant_o[1] = 1'b1; unit1_o = U_LS;
        end
      end else if (need1_i.md) begin
        if (!mul_busy_i && unit0_o != U_MD) begin
          grant_o[1] = 1'b1; unit1_o = U_MD;
        end
      end
    end
    start_o = (grant_o[0] && need0_i.multi) || (grant_o[1] && need1_i.multi);
    extra_o = (grant_o[0] && need0_i.multi) ? need0_i.extra : need1_i.extra;
  end
endmodule

// File: rtl/dual_issue_steer.sv
module dual_issue_steer
  import dd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CLS_W-1:0]  cls0_i,
  input  logic [CLS_W-1:0]  cls1_i,
  input  logic              mul_busy_i,
  output logic              grant0_o,
  output logic              grant1_o,
  output logic [UNIT_W-1:0] unit0_o,
  output logic [UNIT_W-1:0] unit1_o,
  output logic [1:0]        consume_o
);
  localparam int SLOTS = 2;

  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  logic [CLS_W-1:0] cls_arr [SLOTS];
  need_t            need_arr [SLOTS];
  assign cls_arr[0] = cls0_i;
  assign cls_arr[1] = cls1_i;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    dd_classify u_cls (.cls_i(cls_arr[s]), .need_o(need_arr[s]));
  end

  logic              hold_busy, start;
  logic [HOLD_W-1:0] extra;
  logic [1:0]        grant;

  dd_hold u_hold (
    .clk(clk), .rst_n(rst_ok), .start_i(start), .extra_i(extra), .busy_o(hold_busy)
  );

  dd_arbiter u_arb (
    .need0_i(need_arr[0]), .need1_i(need_arr[1]), .hold_i(hold_busy),
    .mul_busy_i(mul_busy_i), .grant_o(grant), .unit0_o(unit0_o),
    .unit1_o(unit1_o), .start_o(start), .extra_o(extra)
  );

  assign grant0_o  = grant[0];
  assign grant1_o  = grant[1];
  assign consume_o = {1'b0, grant[0]} + {1'b0, grant[1]};

  a_r2_in_order: assert property (@(posedge clk) disable iff (!rst_ok)
    grant1_o |-> grant0_o);
  a_r6_distinct_units: assert property (@(posedge clk) disable iff (!rst_ok)
    (grant0_o && grant1_o) |-> (unit0_o != unit1_o));
  a_r7_busy_blocks_md: assert property (@(posedge clk) disable iff (!rst_ok)
    mul_busy_i |-> (unit0_o != U_MD && unit1_o != U_MD));
  a_r8_hold_single_issue: assert property (@(posedge clk) disable iff (!rst_ok)
    hold_busy |-> (!grant1_o && unit0_o != U_PA));
  a_r1_bubble_idle: assert property (@(posedge clk) disable iff (!rst_ok)
    !need_arr[0].vld |-> (consume_o == 2'd0 && unit0_o == U_NONE));
endmodule

// File: tb/dual_issue_steer_tb_top.sv
`timescale 1ns/1ps
module dual_issue_steer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cls0, cls1;
  logic       busy;
  logic       g0, g1;
  logic [2:0] u0, u1;
  logic [1:0] cnt;

  always #2.5 clk = ~clk;

  dual_issue_steer dut_i (
    .clk(clk), .rst_n(rst_n), .cls0_i(cls0), .cls1_i(cls1), .mul_busy_i(busy),
    .grant0_o(g0), .grant1_o(g1), .unit0_o(u0), .unit1_o(u1), .consume_o(cnt)
  );

  typedef struct {
    logic       e0, e1;
    logic [2:0] eu0, eu1;
    logic [1:0] ec;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  task automatic drv(input logic [3:0] a, input logic [3:0] b, input logic mb,
                     input logic e0, input logic e1, input logic [2:0] eu0,
                     input logic [2:0] eu1, input logic [1:0] ec, input string tag);
    exp_t e;
    @(negedge clk);
    cls0 = a; cls1 = b; busy = mb;
    e.e0 = e0; e.e1 = e1; e.eu0 = eu0; e.eu1 = eu1; e.ec = ec; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (g0 !== e.e0 || g1 !== e.e1 || u0 !== e.eu0 || u1 !== e.eu1 || cnt !== e.ec) begin
          n_bad++;
          $display("FAIL %s: got g=%b%b u=%0d,%0d n=%0d exp g=%b%b u=%0d,%0d n=%0d",
                   e.tag, g0, g1, u0, u1, cnt, e.e0, e.e1, e.eu0, e.eu1, e.ec);
        end
      end
    end
  end

  initial begin : watchdog
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; cls0 = 4'd0; cls1 = 4'd0; busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 idle after reset, bubbles and unassigned codes
    drv(4'd0, 4'd0, 0, 0, 0, 0, 0, 0, "R1 reset idle");
    drv(4'd0, 4'd1, 0, 0, 0, 0, 0, 0, "R1 bubble head blocks");
    drv(4'd15, 4'd1, 0, 0, 0, 0, 0, 0, "R1 code 15");
    drv(4'd12, 4'd5, 0, 0, 0, 0, 0, 0, "R1 code 12");
    // R3 simple steering
    drv(4'd1, 4'd1, 0, 1, 1, 1, 2, 2, "R3 any any");
    // R5 pairing asymmetry
    drv(4'd1, 4'd2, 0, 1, 0, 1, 0, 1, "R5 any then restricted");
    drv(4'd2, 4'd1, 0, 1, 1, 2, 1, 2, "R5 restricted then any");
    // R4 restricted pair
    drv(4'd2, 4'd2, 0, 1, 0, 2, 0, 1, "R4 two restricted");
    // R6 branch and load/store
    drv(4'd5, 4'd5, 0, 1, 0, 5, 0, 1, "R6 two branches");
    drv(4'd8, 4'd9, 0, 1, 0, 4, 0, 1, "R6 load store");
    drv(4'd8, 4'd5, 0, 1, 1, 4, 5, 2, "R6 load branch");
    drv(4'd5, 4'd10, 0, 1, 0, 5, 0, 1, "R6 branch then code 10");
    // R7 multiply / divide
    drv(4'd6, 4'd7, 0, 1, 0, 3, 0, 1, "R7 mul div");
    drv(4'd7, 4'd8, 0, 1, 1, 3, 4, 2, "R7 div load");
    drv(4'd6, 4'd1, 1, 0, 0, 0, 0, 0, "R2 R7 busy head blocks younger");
    drv(4'd1, 4'd6, 1, 1, 0, 1, 0, 1, "R7 busy younger mul");
    // R8 two-part window
    drv(4'd3, 4'd2, 0, 1, 1, 1, 2, 2, "R8 two-part issue");
    drv(4'd1, 4'd1, 0, 1, 0, 2, 0, 1, "R8 two-part hold");
    drv(4'd1, 4'd1, 0, 1, 1, 1, 2, 2, "R8 two-part released");
    // R8 three-part window
    drv(4'd4, 4'd8, 0, 1, 1, 1, 4, 2, "R8 three-part issue");
    drv(4'd3, 4'd1, 0, 0, 0, 0, 0, 0, "R8 multi blocked in hold");
    drv(4'd8, 4'd5, 0, 1, 0, 4, 0, 1, "R8 single issue in hold");
    drv(4'd3, 4'd5, 0, 1, 1, 1, 5, 2, "R8 two-part after release");
    drv(4'd0, 4'd0, 0, 0, 0, 0, 0, 0, "R8 bubble in hold");
    drv(4'd2, 4'd5, 0, 1, 1, 2, 5, 2, "R8 free after two-part");
    // R3 pipe A taken by older
    drv(4'd1, 4'd3, 0, 1, 0, 1, 0, 1, "R3 any then two-part");
    drv(4'd0, 4'd0, 0, 0, 0, 0, 0, 0, "R2 final idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule